// File: doc/BRIEF.md
# Indirect-access interrupt redirection register block

This block is the software-visible register file of an I/O interrupt controller. Software reaches all of its state through two 32-bit locations. An 8-bit index is written into a select register at offset 0x00. The 32-bit data window at offset 0x10 is then read or written. The index picks one of three small control registers, or one 32-bit half of a 64-bit redirection entry, with one entry per interrupt pin. The block holds the table, the select register and a 4-bit controller ID. It exports the mask, trigger-mode and remote-IRR bit of every entry to the delivery logic.

A write that changes an entry's mask bit produces a one-cycle mask-change strobe carrying the entry number. A window write can leave an entry level-triggered and unmasked while the delivery logic reports that pin's request as pending. In that case the block issues a one-cycle service strobe with the entry number, and it sets the entry's remote-IRR bit on the following clock edge.

Accesses are sequenced by a three-state controller. The states are `ST_IDLE`, which accepts a request, `ST_RD_RESP`, which presents read data, and `ST_WR_POST`, which presents the write side-effect strobes. There are four transitions. `ST_IDLE`→`ST_RD_RESP` occurs on an accepted read. `ST_IDLE`→`ST_WR_POST` occurs on an accepted write. `ST_RD_RESP`→`ST_IDLE` and `ST_WR_POST`→`ST_IDLE` each occur unconditionally after one cycle. `ST_IDLE` holds while no request is presented.

Top module: `redir_window_regs`

## Requirements
- R1: The select register is 8 bits wide at offset 0x00 and reads back the last value written to it. The data window is at offset 0x10. Any other offset reads as zero, and writes to it change nothing.
- R2: Window index 0x01 reads `{8'h00, NPINS-1, 8'h00, VERSION}`, which with the default parameters is 0x00170011. Writes to that index change nothing.
- R3: Window index 0x00 holds a 4-bit ID, written from data bits 27:24 and read back in bits 27:24 with all other bits zero. Index 0x02 reads the same value, and writes to index 0x02 change nothing.
- R4: For an index of 0x10 or above, the entry number is (index−0x10)>>1. An even index maps to entry bits 31:0 and an odd index to bits 63:32. The entry fields are vector 7:0, delivery mode 10:8, destination mode 11, remote IRR 14, trigger mode 15 (1 = level), mask 16 and destination 63:56. Every other bit reads zero.
- R5: Writing the low half of an entry clears its remote-IRR bit whatever data bit 14 holds. Writing the high half leaves remote IRR unchanged.
- R6: A window write whose entry number is NPINS or more is discarded. A read of such an index returns zero.
- R7: After a window write to an entry, the block checks three conditions: the entry is level-triggered, it is unmasked, and `pend_i` for that pin was high when the write was accepted. If all three hold, `svc_o` is high for exactly the cycle after acceptance with `svc_idx_o` set to the entry, and the entry's remote IRR reads 1 from the cycle after that.
- R8: When a window write changes an entry's mask bit, `mask_evt_o` is high for exactly the cycle after acceptance with `mask_evt_idx_o` set to the entry. No strobe is produced otherwise.
- R9: Reset sets every mask bit and clears the select register, the ID and all other entry fields. After reset the block is ready to accept a request.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is then low for one cycle. Read data is valid, with `rsp_valid` high, in the cycle after acceptance.
- R11: `mask_o`, `trig_o` and `rirr_o` give, bit for bit, the current mask, trigger-mode and remote-IRR bits of each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pend_i | input | NPINS | Per-pin pending request from delivery logic |
| mask_o | output | NPINS | Entry mask bits |
| trig_o | output | NPINS | Entry trigger-mode bits (1 = level) |
| rirr_o | output | NPINS | Entry remote-IRR bits |
| mask_evt_o | output | 1 | Mask-change strobe |
| mask_evt_idx_o | output | IW | Entry number for the mask-change strobe |
| svc_o | output | 1 | Service-request strobe |
| svc_idx_o | output | IW | Entry number for the service strobe |

## Verification
The hardest situation to reach is the remote-IRR life cycle. The bit can only be set through a service strobe, and that needs a level-triggered, unmasked entry whose pending input is already high when the window write lands. The stimulus therefore raises `pend_i` for one pin first. It then programs that entry's low half as level-triggered and unmasked. It follows with a high-half write, which must re-service the entry without clearing remote IRR, and a masked low-half write with data bit 14 set, which must clear it. A behavioural model tracks every entry, and after each step its expected exported vectors are compared with the outputs on every clock.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_POST = 2'd2
    } acc_state_e;

    // one redirection entry, only implemented fields
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       rirr;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
    } rte_t;

    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                   rirr: 1'b0, dmode: 1'b0, dlv: 3'd0,
                                   vec: 8'h00};

    function automatic logic [31:0] pack_lo(input rte_t e);
        return {15'd0, e.mask, e.trig, e.rirr, 2'b00, e.dmode, e.dlv, e.vec};
    endfunction

    function automatic logic [31:0] pack_hi(input rte_t e);
        return {e.dest, 24'd0};
    endfunction

    // entry contents after a window write to one half
    function automatic rte_t apply_write(input rte_t cur, input logic hi,
                                         input logic [31:0] d);
        rte_t r;
        r = cur;
        if (hi) begin
            r.dest = d[31:24];
        end else begin
            r.vec   = d[7:0];
            r.dlv   = d[10:8];
            r.dmode = d[11];
            r.trig  = d[15];
            r.mask  = d[16];
            r.rirr  = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ixr_ctrl.sv
module ixr_ctrl
    import ixr_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          mchg_i,
    input  logic          svc_i,
    input  logic [IW-1:0] idx_i,
    output logic          accept_o,
    output logic          req_ready_o,
    output logic          rsp_valid_o,
    output logic          mask_evt_o,
    output logic          svc_o,
    output logic [IW-1:0] evt_idx_o
);

    acc_state_e    state_q, state_d;
    logic          mchg_q, svc_q;
    logic [IW-1:0] idx_q;

    assign accept_o = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_write ? ST_WR_POST : ST_RD_RESP;
            end
            ST_RD_RESP: state_d = ST_IDLE;
            ST_WR_POST: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // side-effect flags captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchg_q <= 1'b0;
            svc_q  <= 1'b0;
            idx_q  <= '0;
        end else if (accept_o) begin
            mchg_q <= mchg_i && req_write;
            svc_q  <= svc_i && req_write;
            idx_q  <= idx_i;
        end
    end

    // outputs
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        rsp_valid_o = (state_q == ST_RD_RESP);
        mask_evt_o  = (state_q == ST_WR_POST) && mchg_q;
        svc_o       = (state_q == ST_WR_POST) && svc_q;
        evt_idx_o   = idx_q;
    end

    // R10
    access_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready_o) |=> !req_ready_o);

    // R10
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready_o && !req_write) |=> rsp_valid_o);

    // R8
    evt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_o |=> !mask_evt_o);

    // R7
    svc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |=> !svc_o);

endmodule

// File: rtl/ixr_entry.sv
module ixr_entry
    import ixr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lo,
    input  rte_t wr_val,
    input  logic set_rirr,
    output rte_t q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RTE_RESET;
        end else if (wr_en) begin
            q <= wr_val;
        end else if (set_rirr && q.trig) begin
            q.rirr <= 1'b1;
        end
    end

    // R5
    lo_write_clears_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lo) |=> !q.rirr);

    // R7
    rirr_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rirr |-> q.trig);

endmodule

// File: rtl/redir_window_regs.sv
module redir_window_regs
    import ixr_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         IW      = $clog2(NPINS),
    localparam int         EW      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [7:0]       req_offset,
    input  logic [31:0]      req_wdata,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    input  logic [NPINS-1:0] pend_i,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] trig_o,
    output logic [NPINS-1:0] rirr_o,
    output logic             mask_evt_o,
    output logic [IW-1:0]    mask_evt_idx_o,
    output logic             svc_o,
    output logic [IW-1:0]    svc_idx_o
);

    logic [7:0]    sel_q;
    logic [3:0]    id_q;
    logic [31:0]   rdata_q;
    rte_t          tbl [NPINS];

    logic          accept;
    logic [7:0]    tbl_off;
    logic [EW-1:0] ent_num;
    logic          half_hi, sel_is_tbl, ent_ok;
    rte_t          cur, nxt;
    logic          pend_sel;
    logic          win_hit, win_wr;
    logic          mchg, svc_need;
    logic [IW-1:0] evt_idx;
    logic [31:0]   rd_val;

    // index decode
    always_comb begin
        tbl_off    = sel_q - IDX_TBL;
        ent_num    = tbl_off[7:1];
        half_hi    = tbl_off[0];
        sel_is_tbl = (sel_q >= IDX_TBL);
        ent_ok     = sel_is_tbl && (ent_num < EW'(NPINS));
    end

    // selected entry and its pending bit
    always_comb begin
        cur      = RTE_RESET;
        pend_sel = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (ent_num == EW'(i)) begin
                cur      = tbl[i];
                pend_sel = pend_i[i];
            end
        end
    end

    always_comb begin
        nxt      = apply_write(cur, half_hi, req_wdata);
        win_hit  = (req_offset == OFS_WIN) && ent_ok;
        win_wr   = accept && req_write && win_hit;
        mchg     = win_hit && (nxt.mask != cur.mask);
        svc_need = win_hit && nxt.trig && !nxt.mask && pend_sel;
    end

    ixr_ctrl #(.IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .mchg_i     (mchg),
        .svc_i      (svc_need),
        .idx_i      (ent_num[IW-1:0]),
        .accept_o   (accept),
        .req_ready_o(req_ready),
        .rsp_valid_o(rsp_valid),
        .mask_evt_o (mask_evt_o),
        .svc_o      (svc_o),
        .evt_idx_o  (evt_idx)
    );

    assign mask_evt_idx_o = evt_idx;
    assign svc_idx_o      = evt_idx;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_ent
            logic hit_g;
            assign hit_g = (ent_num == EW'(g));
            ixr_entry u_ent (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (win_wr && hit_g),
                .wr_lo   (!half_hi),
                .wr_val  (nxt),
                .set_rirr(svc_o && (evt_idx == IW'(g))),
                .q       (tbl[g])
            );
            assign mask_o[g] = tbl[g].mask;
            assign trig_o[g] = tbl[g].trig;
            assign rirr_o[g] = tbl[g].rirr;
        end
    endgenerate

    // select and ID registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            id_q  <= 4'h0;
        end else if (accept && req_write) begin
            if (req_offset == OFS_SEL) sel_q <= req_wdata[7:0];
            if (req_offset == OFS_WIN && sel_q == IDX_ID) id_q <= req_wdata[27:24];
        end
    end

    // read mux
    always_comb begin
        rd_val = 32'd0;
        if (req_offset == OFS_SEL) begin
            rd_val = {24'd0, sel_q};
        end else if (req_offset == OFS_WIN) begin
            if (sel_q == IDX_ID || sel_q == IDX_ARB)
                rd_val = {4'd0, id_q, 24'd0};
            else if (sel_q == IDX_VER)
                rd_val = {8'd0, 8'(NPINS - 1), 8'd0, VERSION};
            else if (ent_ok)
                rd_val = half_hi ? pack_hi(cur) : pack_lo(cur);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata_q <= 32'd0;
        else if (accept && !req_write) rdata_q <= rd_val;
    end

    assign rsp_rdata = rdata_q;

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(req_write && req_offset == OFS_SEL)) |=> $stable(sel_q));

    // R6
    discard_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && req_offset == OFS_WIN && sel_is_tbl && !ent_ok)
        |=> ($stable(mask_o) && $stable(trig_o) && !mask_evt_o && !svc_o));

    // R5
    lo_clear_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !half_hi) |=> !cur.rirr);

endmodule

// File: tb/redir_window_regs_tb.sv
`timescale 1ns/1ps
module redir_window_regs_tb;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]    req_offset = 8'h00;
    logic [31:0]   req_wdata = 32'd0;
    logic          req_ready, rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] pend = '0;
    logic [NP-1:0] mask_o, trig_o, rirr_o;
    logic          mask_evt_o, svc_o;
    logic [4:0]    mask_evt_idx_o, svc_idx_o;

    always #4 clk = ~clk;

    redir_window_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pend_i(pend),
        .mask_o(mask_o), .trig_o(trig_o), .rirr_o(rirr_o),
        .mask_evt_o(mask_evt_o), .mask_evt_idx_o(mask_evt_idx_o),
        .svc_o(svc_o), .svc_idx_o(svc_idx_o)
    );

    int total = 0, bad = 0;
    bit cmp_en = 0;

    // behavioural model
    int m_sel, m_id;
    int m_vec[NP], m_dlv[NP], m_dm[NP], m_trig[NP], m_mask[NP], m_rirr[NP], m_dest[NP];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_sel = 0; m_id = 0;
        for (int i = 0; i < NP; i++) begin
            m_vec[i] = 0; m_dlv[i] = 0; m_dm[i] = 0; m_trig[i] = 0;
            m_mask[i] = 1; m_rirr[i] = 0; m_dest[i] = 0;
        end
    endtask

    function automatic logic [31:0] mdl_read(input int ofs);
        int e;
        if (ofs == 'h00) return 32'(m_sel);
        if (ofs != 'h10) return 32'd0;
        if (m_sel == 0 || m_sel == 2) return 32'(m_id) << 24;
        if (m_sel == 1) return 32'((NP - 1) << 16 | 'h11);
        if (m_sel < 'h10) return 32'd0;
        e = (m_sel - 'h10) >> 1;
        if (e >= NP) return 32'd0;
        if (m_sel % 2 == 1) return 32'(m_dest[e]) << 24;
        return 32'(m_mask[e] << 16 | m_trig[e] << 15 | m_rirr[e] << 14 |
                   m_dm[e] << 11 | m_dlv[e] << 8 | m_vec[e]);
    endfunction

    task automatic mdl_write(input int ofs, input logic [31:0] d,
                             output bit ev, output bit sv, output int ix);
        int e, old_m;
        ev = 0; sv = 0; ix = 0;
        if (ofs == 'h00) m_sel = int'(d[7:0]);
        else if (ofs == 'h10) begin
            if (m_sel == 0) m_id = int'(d[27:24]);
            else if (m_sel >= 'h10) begin
                e = (m_sel - 'h10) >> 1;
                if (e < NP) begin
                    old_m = m_mask[e];
                    if (m_sel % 2 == 1) m_dest[e] = int'(d[31:24]);
                    else begin
                        m_vec[e] = int'(d[7:0]); m_dlv[e] = int'(d[10:8]);
                        m_dm[e] = int'(d[11]); m_trig[e] = int'(d[15]);
                        m_mask[e] = int'(d[16]); m_rirr[e] = 0;
                    end
                    ix = e;
                    ev = (old_m != m_mask[e]);
                    sv = (m_trig[e] == 1) && (m_mask[e] == 0) && pend[e];
                end
            end
        end
    endtask

    // per-clock comparison of exported vectors (R11)
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [NP-1:0] em, et, er;
            for (int i = 0; i < NP; i++) begin
                em[i] = m_mask[i][0]; et[i] = m_trig[i][0]; er[i] = m_rirr[i][0];
            end
            chk("R11 mask_o", 32'(mask_o), 32'(em));
            chk("R11 trig_o", 32'(trig_o), 32'(et));
            chk("R11 rirr_o", 32'(rirr_o), 32'(er));
        end
    end

    task automatic do_wr(input int ofs, input logic [31:0] d, input string req);
        bit ev, sv; int ix;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_offset = 8'(ofs); req_wdata = d;
        @(posedge clk);
        mdl_write(ofs, d, ev, sv, ix);
        @(negedge clk);
        req_valid = 0;
        chk({req, " ready low after accept (R10)"}, 32'(req_ready), 32'd0);
        chk({req, " mask_evt"}, 32'(mask_evt_o), 32'(ev));
        if (ev) chk({req, " mask_evt_idx"}, 32'(mask_evt_idx_o), 32'(ix));
        chk({req, " svc"}, 32'(svc_o), 32'(sv));
        if (sv) chk({req, " svc_idx"}, 32'(svc_idx_o), 32'(ix));
        @(posedge clk);
        if (sv) m_rirr[ix] = 1;
    endtask

    task automatic do_rd(input int ofs, input string req);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_offset = 8'(ofs);
        @(posedge clk);
        exp = mdl_read(ofs);
        @(negedge clk);
        req_valid = 0;
        chk({req, " rsp_valid (R10)"}, 32'(rsp_valid), 32'd1);
        chk({req, " rdata"}, rsp_rdata, exp);
        @(posedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        mdl_reset();
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        // R9 reset state
        chk("R9 ready after reset", 32'(req_ready), 32'd1);
        chk("R9 no response", 32'(rsp_valid), 32'd0);
        do_rd('h00, "R9 select zero");
        do_rd('h10, "R9 id zero");
        do_wr('h00, 32'h10, "R9 sel entry0");
        do_rd('h10, "R9 entry0 masked");
        // R1 select and stray offsets
        do_wr('h00, 32'hFFFF_FF2B, "R1 sel write");
        do_rd('h00, "R1 sel readback");
        do_wr('h20, 32'h55, "R1 stray write");
        do_rd('h00, "R1 sel unchanged");
        do_rd('h30, "R1 stray read zero");
        // R2 version
        do_wr('h00, 32'h01, "R2 sel ver");
        do_rd('h10, "R2 version");
        do_wr('h10, 32'hFFFF_FFFF, "R2 version write");
        do_rd('h10, "R2 version unchanged");
        // R3 id / arbitration
        do_wr('h00, 32'h00, "R3 sel id");
        do_wr('h10, 32'hA500_0000, "R3 id write");
        do_rd('h10, "R3 id read");
        do_wr('h00, 32'h02, "R3 sel arb");
        do_rd('h10, "R3 arb mirrors id");
        do_wr('h10, 32'h0F00_0000, "R3 arb write");
        do_rd('h10, "R3 arb unchanged");
        do_wr('h00, 32'h00, "R3 sel id again");
        do_rd('h10, "R3 id unchanged");
        // R4 / R8 entry 3
        do_wr('h00, 32'h16, "R4 sel e3 lo");
        do_wr('h10, 32'h0000_8A31, "R8 e3 unmask");
        do_rd('h10, "R4 e3 lo");
        do_wr('h00, 32'h17, "R4 sel e3 hi");
        do_wr('h10, 32'hC3FF_FFFF, "R4 e3 hi write");
        do_rd('h10, "R4 e3 hi");
        do_wr('h00, 32'h16, "R4 sel e3 lo");
        do_rd('h10, "R4 e3 lo kept");
        // R7 / R5 entry 5
        pend[5] = 1'b1;
        do_wr('h00, 32'h1A, "R7 sel e5 lo");
        do_wr('h10, 32'h0000_8040, "R7 e5 level service");
        do_rd('h10, "R7 e5 rirr set");
        do_wr('h00, 32'h1B, "R5 sel e5 hi");
        do_wr('h10, 32'h1100_0000, "R5 hi keeps rirr");
        do_rd('h10, "R5 e5 hi");
        do_wr('h00, 32'h1A, "R5 sel e5 lo");
        do_rd('h10, "R5 rirr still set");
        do_wr('h10, 32'h0001_C040, "R5 lo clears rirr");
        do_rd('h10, "R5 rirr cleared");
        do_wr('h10, 32'h0000_0040, "R7 edge no service");
        // level but masked: neither strobe
        pend[7] = 1'b1;
        do_wr('h00, 32'h1E, "R7 sel e7");
        do_wr('h10, 32'h0001_8000, "R7 masked no service");
        // R6 out of range
        do_wr('h00, 32'h40, "R6 sel e24");
        do_wr('h10, 32'h0000_8000, "R6 discard lo");
        do_rd('h10, "R6 read zero");
        do_wr('h00, 32'hFF, "R6 sel top");
        do_wr('h10, 32'hFFFF_FFFF, "R6 discard hi");
        do_wr('h00, 32'h3E, "R6 sel e23");
        do_rd('h10, "R6 e23 untouched");
        cmp_en = 0;
        summary();
        $finish;
    end

endmodule